// File: doc/BRIEF.md
# Speed Mode and Sampling Tap Control Register

This block is a single 16-bit control register for a card host. It holds the card bus speed mode and the sampling tap that drives an external input delay line. Software writes the mode and a tap value in one word. To commit the tap it also sets an update request bit. The block keeps that bit set while the update is in flight, then clears it. In the same cycle that the bit clears, it moves the tap into the applied-tap output. Software polls the bit to learn when the new tap is in effect.

The delay hardware wraps above its usable range, so the block limits the tap before it applies it. It also tracks the enhanced-strobe enable. A plain HS400 mode turns into its enhanced-strobe variant while the enable is high, and turns back when the enable drops. Reserved mode codes are shown to downstream logic as SD mode. A write that arrives during an update is held and applied when the update finishes.

Top module: `speed_tune_ctrl`

## Requirements
- R1: After reset, `rdData` reads 0, `activeTap` is 0 and `modeOut` is 0.
- R2: A write while no update is pending loads the mode field from bits [2:0] and the tap field from bits [13:8]. Readback puts the mode in [2:0], the tap in [13:8] and the update flag in bit 15, with every other bit 0. A write with bit 15 set makes bit 15 read 1 from the next cycle.
- R3: After it is set, the update flag reads 1 for exactly `UPD_LAT` cycles (4 by default) and then reads 0 without any write.
- R4: `activeTap` keeps its old value while the update flag reads 1. It takes the committed tap in the cycle the flag reads 0 again.
- R5: A write that changes the tap field without bit 15 set leaves `activeTap` unchanged.
- R6: A committed tap of 43 or above gives `activeTap` = 0. Taps 0 to 42 are applied as written.
- R7: Writes that arrive while an update is in flight do not change the readback at first. The last of them is applied in the cycle the update completes. If that write has bit 15 set, a new update starts.
- R8: Mode codes are SD=0, MMC SDR=2, MMC DDR=3, HS200=4, HS400=5 and HS400 enhanced strobe=6. While the stored mode is 5 and `strobeEn` is 1, the mode becomes 6 on the next cycle. While it is 6 and `strobeEn` is 0, it becomes 5 on the next cycle. A write in the same cycle takes precedence.
- R9: `modeOut` shows the stored mode, except that the reserved codes 1 and 7 appear as 0. Readback still returns the raw code.
- R10: A write that arrives in the same cycle as an update completion is applied directly and takes precedence over any held write. The completing update still applies its own tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 16 | Register write data |
| strobeEn | input | 1 | Enhanced-strobe enable level |
| rdData | output | 16 | Register readback |
| modeOut | output | 3 | Mode presented to the bus logic |
| activeTap | output | 6 | Tap applied to the delay line |

## Verification
Two functions can fall in the same cycle: the completion of a tap update and a new register write. The bench provokes this by timing a write with the update bit set so that it lands exactly on the completion edge, with an earlier write already held. It then checks three things: the old tap becomes active, the new tap is in the readback and starts its own update, and the held write is discarded. A second collision, a write of HS400 while the strobe enable is high, is checked by sampling the write first and the strobe conversion one cycle later.

// File: rtl/stc_pkg.sv
package stc_pkg;
  localparam int REG_W     = 16;
  localparam int MODE_W    = 3;
  localparam int TAP_W     = 6;
  localparam int MODE_LSB  = 0;
  localparam int TAP_LSB   = 8;
  localparam int UPD_BIT   = 15;

  typedef enum logic [MODE_W-1:0] {
    MODE_SD       = 3'd0,
    MODE_RSV_LO   = 3'd1,
    MODE_MMC_SDR  = 3'd2,
    MODE_MMC_DDR  = 3'd3,
    MODE_HS200    = 3'd4,
    MODE_HS400    = 3'd5,
    MODE_HS400_ES = 3'd6,
    MODE_RSV_HI   = 3'd7
  } busMode_e;

  typedef struct packed {
    logic             load;
    logic [REG_W-1:0] src;
    logic             apply;
  } ctlStrobe_t;
endpackage

// File: rtl/stc_ctrl.sv
module stc_ctrl
  import stc_pkg::*;
#(
  parameter int UPD_LAT = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic             busy,
  output ctlStrobe_t       ctl
);
  localparam int CNT_W = (UPD_LAT < 2) ? 1 : $clog2(UPD_LAT);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(UPD_LAT - 1);

  logic [CNT_W-1:0] cnt;
  logic             pendValid;
  logic [REG_W-1:0] pendData;
  logic             done;

  assign done = busy && (cnt == CNT_LAST);

  always_comb begin
    ctl.load  = 1'b0;
    ctl.src   = wrData;
    ctl.apply = done;
    if (!busy || done) begin
      if (wrEn) begin
        ctl.load = 1'b1;
        ctl.src  = wrData;
      end else if (done && pendValid) begin
        ctl.load = 1'b1;
        ctl.src  = pendData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      cnt       <= '0;
      pendValid <= 1'b0;
      pendData  <= '0;
    end else begin
      if (ctl.load) begin
        busy <= ctl.src[UPD_BIT];
        cnt  <= '0;
      end else if (done) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt + 1'b1;
      end

      if (done) begin
        pendValid <= 1'b0;
      end else if (busy && wrEn) begin
        pendValid <= 1'b1;
        pendData  <= wrData;
      end
    end
  end
endmodule

// File: rtl/stc_data.sv
module stc_data
  import stc_pkg::*;
#(
  parameter int TAP_USABLE = 43
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strobeEn,
  input  ctlStrobe_t        ctl,
  output logic [MODE_W-1:0] modeReg,
  output logic [TAP_W-1:0]  tapReg,
  output logic [TAP_W-1:0]  activeTap,
  output logic [MODE_W-1:0] modeOut
);
  localparam logic [TAP_W-1:0] TAP_LIMIT = TAP_W'(TAP_USABLE);

  logic [TAP_W-1:0] tapLimited;

  assign tapLimited = (tapReg >= TAP_LIMIT) ? '0 : tapReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg   <= MODE_SD;
      tapReg    <= '0;
      activeTap <= '0;
    end else begin
      if (ctl.load) begin
        modeReg <= ctl.src[MODE_LSB +: MODE_W];
        tapReg  <= ctl.src[TAP_LSB +: TAP_W];
      end else if (modeReg == MODE_HS400 && strobeEn) begin
        modeReg <= MODE_HS400_ES;
      end else if (modeReg == MODE_HS400_ES && !strobeEn) begin
        modeReg <= MODE_HS400;
      end
      if (ctl.apply) begin
        activeTap <= tapLimited;
      end
    end
  end

  always_comb begin
    unique case (modeReg)
      MODE_RSV_LO, MODE_RSV_HI: modeOut = MODE_SD;
      default:                  modeOut = modeReg;
    endcase
  end
endmodule

// File: rtl/speed_tune_ctrl.sv
module speed_tune_ctrl
  import stc_pkg::*;
#(
  parameter int UPD_LAT    = 4,
  parameter int TAP_USABLE = 43
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [15:0] wrData,
  input  logic        strobeEn,
  output logic [15:0] rdData,
  output logic [2:0]  modeOut,
  output logic [5:0]  activeTap
);
  ctlStrobe_t        ctl;
  logic              busy;
  logic [MODE_W-1:0] modeReg;
  logic [TAP_W-1:0]  tapReg;

  stc_ctrl #(.UPD_LAT(UPD_LAT)) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrData (wrData),
    .busy   (busy),
    .ctl    (ctl)
  );

  stc_data #(.TAP_USABLE(TAP_USABLE)) i_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobeEn  (strobeEn),
    .ctl       (ctl),
    .modeReg   (modeReg),
    .tapReg    (tapReg),
    .activeTap (activeTap),
    .modeOut   (modeOut)
  );

  always_comb begin
    rdData                          = '0;
    rdData[UPD_BIT]                 = busy;
    rdData[TAP_LSB +: TAP_W]        = tapReg;
    rdData[MODE_LSB +: MODE_W]      = modeReg;
  end
endmodule

// File: rtl/speed_tune_ctrl_chk.sv
module speed_tune_ctrl_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [15:0] wrData,
  input logic        strobeEn,
  input logic [15:0] rdData,
  input logic [2:0]  modeOut,
  input logic [5:0]  activeTap
);
  a_r2_idle_write_loads: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !rdData[15]) |=> (rdData[13:8] == $past(wrData[13:8]) &&
                               rdData[2:0] == $past(wrData[2:0]) &&
                               rdData[15] == $past(wrData[15])));

  a_r4_tap_moves_after_update: assert property (@(posedge clk) disable iff (!rstN)
    (activeTap != $past(activeTap)) |-> ($past(rdData[15]) && !$past(wrEn && !rdData[15])));

  a_r6_tap_in_range: assert property (@(posedge clk) disable iff (!rstN)
    activeTap <= 6'd42);

  a_r8_enter_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[2:0] == 3'd5 && strobeEn && !wrEn && !rdData[15]) |=> (rdData[2:0] == 3'd6));

  a_r8_leave_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[2:0] == 3'd6 && !strobeEn && !wrEn && !rdData[15]) |=> (rdData[2:0] == 3'd5));

  a_r9_no_reserved_out: assert property (@(posedge clk) disable iff (!rstN)
    (modeOut != 3'd1 && modeOut != 3'd7));
endmodule

bind speed_tune_ctrl speed_tune_ctrl_chk i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .wrEn      (wrEn),
  .wrData    (wrData),
  .strobeEn  (strobeEn),
  .rdData    (rdData),
  .modeOut   (modeOut),
  .activeTap (activeTap)
);

// File: tb/test_speed_tune_ctrl.sv
`timescale 1ns/1ps
module test_speed_tune_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic        strobeEn = 1'b0;
  logic [15:0] rdData;
  logic [2:0]  modeOut;
  logic [5:0]  activeTap;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  speed_tune_ctrl i_speed_tune_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .strobeEn(strobeEn), .rdData(rdData), .modeOut(modeOut), .activeTap(activeTap)
  );

  function automatic logic [15:0] word(input bit upd, input logic [5:0] tap, input logic [2:0] mode);
    return {upd, 1'b0, tap, 5'b0, mode};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // caller sits just after a falling edge
  task automatic wr(input logic [15:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic tReset();
    chk("R1 rdData", rdData, 16'h0);
    chk("R1 activeTap", 16'(activeTap), 16'h0);
    chk("R1 modeOut", 16'(modeOut), 16'h0);
  endtask

  task automatic tUpdate();
    wr(word(1, 6'd17, 3'd4));
    chk("R2 readback", rdData, word(1, 6'd17, 3'd4));
    chk("R4 tap held", 16'(activeTap), 16'd0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 flag still set", 16'(rdData[15]), 16'd1);
      chk("R4 tap held", 16'(activeTap), 16'd0);
    end
    @(negedge clk);
    chk("R3 flag cleared", 16'(rdData[15]), 16'd0);
    chk("R4 tap applied", 16'(activeTap), 16'd17);
  endtask

  task automatic tNoUpdate();
    wr(word(0, 6'd30, 3'd2));
    chk("R5 readback", rdData, word(0, 6'd30, 3'd2));
    repeat (6) @(negedge clk);
    chk("R5 tap unchanged", 16'(activeTap), 16'd17);
  endtask

  task automatic commit(input logic [5:0] tap, input logic [5:0] expTap, input string req);
    wr(word(1, tap, 3'd4));
    repeat (4) @(negedge clk);
    chk(req, 16'(activeTap), 16'(expTap));
  endtask

  task automatic tWrap();
    commit(6'd42, 6'd42, "R6 tap 42 kept");
    commit(6'd43, 6'd0,  "R6 tap 43 wraps");
    commit(6'd5,  6'd5,  "R6 tap 5 kept");
    commit(6'd63, 6'd0,  "R6 tap 63 wraps");
  endtask

  task automatic tHeld();
    wr(word(1, 6'd10, 3'd4));
    wr(word(0, 6'd20, 3'd2));
    chk("R7 held write hidden", rdData, word(1, 6'd10, 3'd4));
    wr(word(0, 6'd30, 3'd3));
    @(negedge clk);
    @(negedge clk);
    chk("R7 last held applied", rdData, word(0, 6'd30, 3'd3));
    chk("R7 committed tap", 16'(activeTap), 16'd10);
    repeat (5) @(negedge clk);
    chk("R7 held no update", 16'(activeTap), 16'd10);
  endtask

  task automatic tCollide();
    wr(word(1, 6'd11, 3'd4));
    wr(word(1, 6'd22, 3'd2));
    @(negedge clk);
    @(negedge clk);
    wr(word(1, 6'd7, 3'd3));
    chk("R10 old tap applied", 16'(activeTap), 16'd11);
    chk("R10 new write wins", rdData, word(1, 6'd7, 3'd3));
    repeat (3) @(negedge clk);
    chk("R10 second update busy", 16'(rdData[15]), 16'd1);
    @(negedge clk);
    chk("R10 second tap applied", 16'(activeTap), 16'd7);
    chk("R10 flag cleared", 16'(rdData[15]), 16'd0);
  endtask

  task automatic tStrobe();
    strobeEn = 1'b0;
    wr(word(0, 6'd1, 3'd5));
    chk("R8 plain HS400", 16'(rdData[2:0]), 16'd5);
    strobeEn = 1'b1;
    @(negedge clk);
    chk("R8 enter strobe", 16'(rdData[2:0]), 16'd6);
    chk("R8 modeOut strobe", 16'(modeOut), 16'd6);
    strobeEn = 1'b0;
    @(negedge clk);
    chk("R8 leave strobe", 16'(rdData[2:0]), 16'd5);
    strobeEn = 1'b1;
    wr(word(0, 6'd1, 3'd5));
    chk("R8 write wins", 16'(rdData[2:0]), 16'd5);
    @(negedge clk);
    chk("R8 convert after write", 16'(rdData[2:0]), 16'd6);
    wr(word(0, 6'd1, 3'd4));
    @(negedge clk);
    chk("R8 HS200 untouched", 16'(rdData[2:0]), 16'd4);
    strobeEn = 1'b0;
  endtask

  task automatic tReserved();
    wr(word(0, 6'd0, 3'd1));
    chk("R9 raw code 1", 16'(rdData[2:0]), 16'd1);
    chk("R9 code 1 as SD", 16'(modeOut), 16'd0);
    wr(word(0, 6'd0, 3'd7));
    chk("R9 code 7 as SD", 16'(modeOut), 16'd0);
    wr(word(0, 6'd0, 3'd3));
    chk("R9 DDR passes", 16'(modeOut), 16'd3);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tUpdate();
    tNoUpdate();
    tWrap();
    tHeld();
    tCollide();
    tStrobe();
    tReserved();
    finish();
  end
endmodule